// File: doc/BRIEF.md
# Two-Rail Serial Word Receiver with Byte Read Port

This block takes a return-to-zero avionics serial stream that an external line receiver has already turned into two logic rails. One rail pulses for a one bit, the other rail pulses for a zero bit, and both low means null. The block recovers the bit timing from the pulses themselves. It shifts each bit into a word register. It frames words by measuring the null time between them against a slow, separate gap clock.

When the last bit of a full word arrives, the word is checked and moved into a holding buffer, and a ready flag rises. A host then takes the word as a sequence of bytes, one byte per read strobe. The byte pointer starts over whenever a newer word replaces the buffer. Short, long and (optionally) bad-parity words raise a sticky error flag.

All inputs are sampled in the system clock domain. This includes the gap clock, whose rising edges are counted as ticks.

Top module: `a429_rx_bytebus`

## Requirements
- R1: After synchronous reset `rst`, `data_rdy` and `err` are 0 and `rd_data` is 0.
- R2: A low-to-high pulse on `rail_one` out of the null state (both rails low) records a 1. A pulse on `rail_zero` records a 0. The first bit received lands in bit 0 of the word and the last in bit 31.
- R3: Both rails high at once records no bit, and a rail that stays high as the other falls records no bit either.
- R4: On the 32nd bit of a word, if `par_en` is low or the word's parity is good, the word is copied into the buffer and `data_rdy` goes to 1.
- R5: `rd_data` shows buffer byte k (bits 8k+7..8k). After a load k is 0. Each `rd_stb` pulse advances k, and after byte 3 k wraps back to 0.
- R6: A `rd_stb` pulse clears `data_rdy` unless a load happens in the same cycle.
- R7: A load resets the byte pointer to byte 0, even in the middle of a read sequence.
- R8: With `par_en` high, a word whose 32 bits hold an even number of ones is not loaded and sets `err`. With `par_en` low, parity is not checked.
- R9: A null gap of GAP_TICKS (3) rising edges of `gap_clk` ends the word. If a nonzero count other than 32 bits arrived, `err` is set. The partial bits are discarded in either case, and the next word assembles from an empty register.
- R10: `err` stays set until the next word is loaded, which clears it.
- R11: A null gap shorter than GAP_TICKS gap-clock edges does not end the word; the bits on either side of it join into one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_one | input | 1 | Logic-level rail that pulses for a one bit |
| rail_zero | input | 1 | Logic-level rail that pulses for a zero bit |
| gap_clk | input | 1 | Slow clock whose rising edges time the inter-word null |
| par_en | input | 1 | Enables the odd-parity check |
| rd_stb | input | 1 | One-cycle read strobe; advances the byte pointer |
| rd_data | output | 8 | Currently selected buffer byte |
| data_rdy | output | 1 | A new word is waiting and has not been read |
| err | output | 1 | Sticky framing or parity error |

## Verification
The bench builds the block with its defaults: a 32-bit word, 8-bit bytes, a two-stage synchroniser, a three-tick gap and odd parity. It drives the gap clock at one eighth of the system rate. Inter-bit nulls therefore stay well under three ticks, while the inter-word gaps exceed them comfortably. This makes it possible to hit words cut short and stretched long, a short gap in mid-word, and a load arriving mid-read. It also reaches the parity acceptance and rejection cases, and a word closing at exactly 32 bits with parity checking both on and off.

// File: rtl/a429rx_pkg.sv
package a429rx_pkg;

   // decoded rail state after synchronisation
   typedef enum logic [1:0] {
      RAIL_NULL = 2'b00,
      RAIL_ZERO = 2'b01,
      RAIL_ONE  = 2'b10,
      RAIL_BAD  = 2'b11
   } rail_e;

   function automatic rail_e rail_classify(input logic one_lvl, input logic zero_lvl);
      return rail_e'({one_lvl, zero_lvl});
   endfunction

endpackage

// File: rtl/a429rx_rail_decoder.sv
module a429rx_rail_decoder
   import a429rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic rail_one,
   input  logic rail_zero,
   input  logic gap_clk,
   output logic ev_one,
   output logic ev_zero,
   output logic null_now,
   output logic gap_tick
);
   localparam int NSIG = 3;

   logic [NSIG-1:0] sync_q [SYNC_STAGES];
   logic [NSIG-1:0] last_q;
   rail_e           st_now;
   rail_e           st_prev;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) sync_q[s] <= '0;
               else     sync_q[s] <= {gap_clk, rail_zero, rail_one};
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) sync_q[s] <= '0;
               else     sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= '0;
      else     last_q <= sync_q[SYNC_STAGES-1];
   end

   always_comb begin
      st_now   = rail_classify(sync_q[SYNC_STAGES-1][0], sync_q[SYNC_STAGES-1][1]);
      st_prev  = rail_classify(last_q[0], last_q[1]);
      ev_one   = (st_now == RAIL_ONE)  && (st_prev == RAIL_NULL);
      ev_zero  = (st_now == RAIL_ZERO) && (st_prev == RAIL_NULL);
      null_now = (st_now == RAIL_NULL);
      gap_tick = sync_q[SYNC_STAGES-1][2] && !last_q[2];
   end

endmodule

// File: rtl/a429rx_gap_timer.sv
module a429rx_gap_timer #(
   parameter int GAP_TICKS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic null_now,
   input  logic gap_tick,
   input  logic word_open,
   output logic word_end
);
   localparam int GW = $clog2(GAP_TICKS + 1);

   logic [GW-1:0] tick_cnt;

   always_ff @(posedge clk) begin
      if (rst || !null_now)
         tick_cnt <= '0;
      else if (gap_tick && (tick_cnt < GW'(GAP_TICKS)))
         tick_cnt <= tick_cnt + GW'(1);
   end

   // assembler clears its count on this cycle, so the pulse is single
   assign word_end = (tick_cnt == GW'(GAP_TICKS)) && word_open;

endmodule

// File: rtl/a429rx_word_assembler.sv
module a429rx_word_assembler #(
   parameter int WORD_BITS  = 32,
   parameter bit PARITY_ODD = 1'b1,
   localparam int CNT_W     = $clog2(WORD_BITS + 2)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ev_one,
   input  logic                 ev_zero,
   input  logic                 word_end,
   input  logic                 par_en,
   output logic [CNT_W-1:0]     bit_cnt,
   output logic                 load,
   output logic [WORD_BITS-1:0] load_word,
   output logic                 err_set
);
   logic [WORD_BITS-1:0] shreg;
   logic                 ev_any;
   logic                 at_last;
   logic                 par_ok;
   logic                 frame_bad;

   assign ev_any    = ev_one || ev_zero;
   assign load_word = {ev_one, shreg[WORD_BITS-1:1]};
   assign at_last   = ev_any && (bit_cnt == CNT_W'(WORD_BITS - 1));

   generate
      if (PARITY_ODD) begin : g_par_odd
         assign par_ok = (^load_word) == 1'b1;
      end else begin : g_par_even
         assign par_ok = (^load_word) == 1'b0;
      end
   endgenerate

   assign load      = at_last && (!par_en || par_ok);
   assign frame_bad = word_end && (bit_cnt != CNT_W'(WORD_BITS));
   assign err_set   = frame_bad || (at_last && par_en && !par_ok);

   always_ff @(posedge clk) begin
      if (rst || word_end) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (ev_any) begin
         shreg <= load_word;
         if (bit_cnt < CNT_W'(WORD_BITS + 1))
            bit_cnt <= bit_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/a429rx_byte_server.sv
module a429rx_byte_server #(
   parameter int WORD_BITS = 32,
   parameter int BYTE_W    = 8,
   localparam int NBYTES   = WORD_BITS / BYTE_W,
   localparam int PTR_W    = $clog2(NBYTES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [WORD_BITS-1:0] load_word,
   input  logic                 err_set,
   input  logic                 rd_stb,
   output logic [BYTE_W-1:0]    rd_data,
   output logic [PTR_W-1:0]     rd_ptr,
   output logic                 data_rdy,
   output logic                 err
);
   logic [WORD_BITS-1:0] buf_q;
   logic [BYTE_W-1:0]    lanes [NBYTES];

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         assign lanes[g] = buf_q[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign rd_data = lanes[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q    <= '0;
         rd_ptr   <= '0;
         data_rdy <= 1'b0;
      end else if (load) begin
         buf_q    <= load_word;
         rd_ptr   <= '0;
         data_rdy <= 1'b1;
      end else if (rd_stb) begin
         data_rdy <= 1'b0;
         rd_ptr   <= (rd_ptr == PTR_W'(NBYTES - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          err <= 1'b0;
      else if (err_set) err <= 1'b1;
      else if (load)    err <= 1'b0;
   end

endmodule

// File: rtl/a429_rx_bytebus.sv
module a429_rx_bytebus #(
   parameter int WORD_BITS   = 32,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_TICKS   = 3,
   parameter bit PARITY_ODD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rail_one,
   input  logic              rail_zero,
   input  logic              gap_clk,
   input  logic              par_en,
   input  logic              rd_stb,
   output logic [BYTE_W-1:0] rd_data,
   output logic              data_rdy,
   output logic              err
);
   localparam int NBYTES = WORD_BITS / BYTE_W;
   localparam int PTR_W  = $clog2(NBYTES);
   localparam int CNT_W  = $clog2(WORD_BITS + 2);

   generate
      if (WORD_BITS % BYTE_W != 0) begin : g_bad_split
         $error("WORD_BITS must be a multiple of BYTE_W");
      end
      if (NBYTES < 2) begin : g_bad_nbytes
         $error("word must hold at least two bytes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GAP_TICKS < 1) begin : g_bad_gap
         $error("GAP_TICKS must be at least 1");
      end
   endgenerate

   logic                 ev_one;
   logic                 ev_zero;
   logic                 null_now;
   logic                 gap_tick;
   logic                 word_end;
   logic [CNT_W-1:0]     bit_cnt;
   logic                 buf_load;
   logic [WORD_BITS-1:0] load_word;
   logic                 err_set;
   logic [PTR_W-1:0]     rd_ptr;

   a429rx_rail_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
      .clk(clk), .rst(rst), .rail_one(rail_one), .rail_zero(rail_zero),
      .gap_clk(gap_clk), .ev_one(ev_one), .ev_zero(ev_zero),
      .null_now(null_now), .gap_tick(gap_tick)
   );

   a429rx_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
      .clk(clk), .rst(rst), .null_now(null_now), .gap_tick(gap_tick),
      .word_open(bit_cnt != '0), .word_end(word_end)
   );

   a429rx_word_assembler #(.WORD_BITS(WORD_BITS), .PARITY_ODD(PARITY_ODD)) u_asm (
      .clk(clk), .rst(rst), .ev_one(ev_one), .ev_zero(ev_zero),
      .word_end(word_end), .par_en(par_en), .bit_cnt(bit_cnt),
      .load(buf_load), .load_word(load_word), .err_set(err_set)
   );

   a429rx_byte_server #(.WORD_BITS(WORD_BITS), .BYTE_W(BYTE_W)) u_srv (
      .clk(clk), .rst(rst), .load(buf_load), .load_word(load_word),
      .err_set(err_set), .rd_stb(rd_stb), .rd_data(rd_data),
      .rd_ptr(rd_ptr), .data_rdy(data_rdy), .err(err)
   );

endmodule

// File: rtl/a429rx_checker.sv
module a429rx_checker #(
   parameter int WORD_BITS = 32,
   parameter int BYTE_W    = 8,
   localparam int NBYTES   = WORD_BITS / BYTE_W,
   localparam int PTR_W    = $clog2(NBYTES),
   localparam int CNT_W    = $clog2(WORD_BITS + 2)
) (
   input logic             clk,
   input logic             rst,
   input logic             rd_stb,
   input logic             data_rdy,
   input logic             err,
   input logic             buf_load,
   input logic             err_set,
   input logic             word_end,
   input logic             ev_one,
   input logic             ev_zero,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [PTR_W-1:0] rd_ptr
);
   // R2: every recovered bit advances the count until it saturates
   p_bit_counts_r2: assert property (@(posedge clk) disable iff (rst)
      (ev_one || ev_zero) && (bit_cnt < CNT_W'(WORD_BITS + 1))
      |=> bit_cnt == $past(bit_cnt) + CNT_W'(1));

   p_load_sets_rdy_r4: assert property (@(posedge clk) disable iff (rst)
      buf_load |=> data_rdy);

   p_read_clears_rdy_r6: assert property (@(posedge clk) disable iff (rst)
      rd_stb && !buf_load |=> !data_rdy);

   p_load_restarts_ptr_r7: assert property (@(posedge clk) disable iff (rst)
      buf_load |=> rd_ptr == '0);

   p_gap_bad_len_r9: assert property (@(posedge clk) disable iff (rst)
      word_end && (bit_cnt != CNT_W'(WORD_BITS)) |=> err);

   p_gap_clears_count_r9: assert property (@(posedge clk) disable iff (rst)
      word_end |=> bit_cnt == '0);

   p_load_clears_err_r10: assert property (@(posedge clk) disable iff (rst)
      buf_load && !err_set |=> !err);

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      err && !buf_load |=> err);
endmodule

bind a429_rx_bytebus a429rx_checker #(.WORD_BITS(WORD_BITS), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst(rst), .rd_stb(rd_stb), .data_rdy(data_rdy), .err(err),
   .buf_load(buf_load), .err_set(err_set), .word_end(word_end),
   .ev_one(ev_one), .ev_zero(ev_zero), .bit_cnt(bit_cnt), .rd_ptr(rd_ptr)
);

// File: tb/sim_a429_rx_bytebus.sv
`timescale 1ns/1ps
module sim_a429_rx_bytebus;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rail_one = 1'b0;
   logic       rail_zero = 1'b0;
   logic       gap_clk = 1'b0;
   logic       par_en = 1'b0;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic       data_rdy;
   logic       err;

   always #2.5 clk = ~clk;

   a429_rx_bytebus u0 (
      .clk(clk), .rst(rst), .rail_one(rail_one), .rail_zero(rail_zero),
      .gap_clk(gap_clk), .par_en(par_en), .rd_stb(rd_stb),
      .rd_data(rd_data), .data_rdy(data_rdy), .err(err)
   );

   // gap clock: one eighth of the system rate
   initial forever begin
      repeat (4) @(negedge clk);
      gap_clk = ~gap_clk;
   end

   // reference model state
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 0;
   logic [31:0] m_buf = '0;
   logic [31:0] m_word = '0;
   int          m_ptr = 0;
   int          m_cnt = 0;
   bit          m_rdy = 0;
   bit          m_err = 0;

   task automatic expect_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare(string req);
      expect_eq(req, "data_rdy", int'(data_rdy), int'(m_rdy));
      expect_eq(req, "err", int'(err), int'(m_err));
      expect_eq(req, "rd_data", int'(rd_data), int'(m_buf[m_ptr*8 +: 8]));
   endtask

   task automatic model_bit(bit b);
      if (m_cnt < 32) m_word[m_cnt] = b;
      if (m_cnt == 31) begin
         if (!par_en || ($countones(m_word) % 2 == 1)) begin
            m_buf = m_word; m_ptr = 0; m_rdy = 1; m_err = 0;
         end else begin
            m_err = 1;
         end
      end
      if (m_cnt < 33) m_cnt++;
   endtask

   task automatic send_bit(bit b);
      @(negedge clk);
      if (b) rail_one = 1'b1; else rail_zero = 1'b1;
      repeat (3) @(negedge clk);
      rail_one = 1'b0; rail_zero = 1'b0;
      repeat (3) @(negedge clk);
      model_bit(b);
   endtask

   task automatic send_both();
      @(negedge clk);
      rail_one = 1'b1; rail_zero = 1'b1;
      repeat (3) @(negedge clk);
      rail_one = 1'b0; rail_zero = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_bits(logic [31:0] w, int first, int last);
      for (int i = first; i <= last; i++) send_bit(w[i]);
   endtask

   task automatic send_gap();
      repeat (48) @(negedge clk);
      if (m_cnt != 0 && m_cnt != 32) m_err = 1;
      m_cnt = 0; m_word = '0;
   endtask

   task automatic read_byte();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      m_ptr = (m_ptr + 1) % 4;
      m_rdy = 0;
   endtask

   function automatic logic [31:0] odd_par(logic [31:0] w);
      logic [31:0] r = w;
      r[31] = ~(^w[30:0]);
      return r;
   endfunction

   function automatic logic [31:0] even_par(logic [31:0] w);
      logic [31:0] r = w;
      r[31] = ^w[30:0];
      return r;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] w;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      compare("R1");
      send_gap();

      // R2 R4: plain word, parity off
      w = 32'hA5C3_0F12;
      send_bits(w, 0, 31);
      compare("R4");
      send_gap();
      compare("R2");

      // R5 R6: read all bytes then wrap
      for (int k = 0; k < 4; k++) begin
         read_byte();
         compare("R5");
      end
      compare("R6");

      // R3: both rails high in mid-word is ignored
      w = 32'h1357_9BDF;
      send_bits(w, 0, 9);
      send_both();
      send_bits(w, 10, 31);
      compare("R3");
      send_gap();

      // R8: parity enabled, even word rejected
      par_en = 1'b1;
      read_byte();
      w = even_par(32'h0BAD_F00D);
      send_bits(w, 0, 31);
      compare("R8");
      send_gap();
      compare("R8");

      // R10: good word clears error
      w = odd_par(32'h2468_ACE0);
      send_bits(w, 0, 31);
      compare("R10");
      send_gap();

      // R9: short word discarded, next word starts clean
      w = 32'hFFFF_FFFF;
      send_bits(w, 0, 19);
      send_gap();
      compare("R9");
      w = odd_par(32'h0000_0F0F);
      send_bits(w, 0, 31);
      compare("R9");
      send_gap();

      // R9: long word loads at bit 32, then errors at the gap
      w = odd_par(32'h7654_3210);
      send_bits(w, 0, 31);
      send_bit(1'b1);
      send_bit(1'b0);
      compare("R9");
      send_gap();
      compare("R9");

      // R7: load mid-read restarts at byte 0
      read_byte();
      read_byte();
      compare("R5");
      w = odd_par(32'hC0DE_5A5A);
      send_bits(w, 0, 31);
      compare("R7");
      send_gap();
      read_byte();
      compare("R7");

      // R11: short gap inside a word does not split it
      w = odd_par(32'h3C3C_8181);
      send_bits(w, 0, 15);
      repeat (10) @(negedge clk);
      send_bits(w, 16, 31);
      compare("R11");
      send_gap();

      // R8: parity disabled accepts even word
      par_en = 1'b0;
      w = even_par(32'h5555_0001);
      send_bits(w, 0, 31);
      compare("R8");
      send_gap();
      read_byte();
      compare("R8");

      finish_run();
   end
endmodule